// File: doc/BRIEF.md
# Fetch Address Breakpoint Bank

This block holds a small set of programmable slots that watch the instruction fetch stream. Each slot stores a word address and a choice of halfword. When a fetch lands on a programmed halfword, the bank raises a breakpoint flag one cycle later. The flag comes with the number of the slot that matched and with the halfword the fetch addressed. A debug agent configures the bank through a write-only register port. Offset 0 is the global control word, and offset 1+i is the word for slot i.

Only detection is built here. Redirecting fetches to patch memory, decoding instructions and stopping the core are the job of neighbouring logic. That logic acts on the registered flag.

Top module: `fetch_bkpt_bank`

## Requirements
- R1: After reset, `bp_hit` is 0, the global enable is clear and every slot is disabled, so no fetch produces a hit until software programs the bank.
- R2: A write to offset 0 changes the global enable to `cfg_wdata[0]` only when `cfg_wdata[1]` (the key) is 1 in the same write. A keyless write to offset 0 leaves the global enable unchanged.
- R3: A write to offset 1+i programs slot i as follows. Bit 0 is the slot enable and bits 28:2 are the compare address. Bits 29 and 1 of the written word are discarded. On the fetch side, address bits 31:29 and bit 0 take no part in the compare.
- R4: Slot bit 30 arms the lower halfword, which matches a fetch with address bit 1 = 0. Slot bit 31 arms the upper halfword, which matches a fetch with address bit 1 = 1. With both bits set, either halfword matches. With neither bit set, the slot never matches.
- R5: A slot matches only while its own enable and the global enable are both 1.
- R6: When several slots match the same fetch, `bp_slot` reports the lowest-numbered one.
- R7: `bp_hit`, `bp_slot` and `bp_upper` are registered. They describe the fetch presented at the previous rising edge, and `bp_upper` equals bit 1 of that fetch address. Register writes take effect for fetches from the following edge on.
- R8: A cycle with `fetch_valid` low produces `bp_hit` = 0 in the next cycle, whatever the address.
- R9: Writes to offsets above NUM_SLOTS change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_off | input | OFF_W | Word offset: 0 is control, 1+i is slot i |
| cfg_wdata | input | 32 | Write data |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| bp_hit | output | 1 | Breakpoint hit for the previous cycle's fetch |
| bp_slot | output | SLOT_W | Lowest matching slot |
| bp_upper | output | 1 | Bit 1 of the fetch that hit |

## Verification
All three outputs are due exactly one rising edge after the fetch they describe. A register write affects only the fetches sampled at the edges after the one that captures it. The bench model follows the same timing. At each rising edge it computes the expected result from its own copy of the registers as they stood before that edge, and only then applies any pending write. The design outputs are compared against this result at the following falling edge, when both have settled, so every result is checked in the cycle it is due.

// File: rtl/fetch_bkpt_bank.sv
module fetch_bkpt_bank #(
  parameter int NUM_SLOTS = 4,
  localparam int OFF_W  = $clog2(NUM_SLOTS + 1),
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [31:0]       cfg_wdata,
  input  logic              fetch_valid,
  input  logic [31:0]       fetch_addr,
  output logic              bp_hit,
  output logic [SLOT_W-1:0] bp_slot,
  output logic              bp_upper
);

  logic                 glob_en;
  logic [NUM_SLOTS-1:0] slot_en, slot_lo, slot_hi, match;
  logic [26:0]          slot_addr [NUM_SLOTS];
  logic [SLOT_W-1:0]    win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                    glob_en <= 1'b0;
    else if (cfg_we && cfg_off == '0 && cfg_wdata[1]) glob_en <= cfg_wdata[0];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        slot_en[i]   <= 1'b0;
        slot_lo[i]   <= 1'b0;
        slot_hi[i]   <= 1'b0;
        slot_addr[i] <= '0;
      end else if (cfg_we && cfg_off == OFF_W'(i + 1)) begin
        slot_en[i]   <= cfg_wdata[0];
        slot_lo[i]   <= cfg_wdata[30];
        slot_hi[i]   <= cfg_wdata[31];
        slot_addr[i] <= cfg_wdata[28:2];
      end

    assign match[i] = fetch_valid && glob_en && slot_en[i]
                      && slot_addr[i] == fetch_addr[28:2]
                      && (fetch_addr[1] ? slot_hi[i] : slot_lo[i]);
  end

  always_comb begin
    win = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (match[i]) win = SLOT_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bp_hit   <= 1'b0;
      bp_slot  <= '0;
      bp_upper <= 1'b0;
    end else begin
      bp_hit   <= |match;
      bp_slot  <= win;
      bp_upper <= fetch_addr[1];
    end

  assert_keyless_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_off == '0 && !cfg_wdata[1]) |=> $stable(glob_en));

  assert_needs_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> $past(glob_en));

  assert_upper_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |-> bp_upper == $past(fetch_addr[1]));

  assert_idle_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !bp_hit);

  assert_high_offset_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_off) > NUM_SLOTS) |=> ($stable(slot_en) && $stable(glob_en)
                                             && $stable(slot_lo) && $stable(slot_hi)));

endmodule

// File: tb/fetch_bkpt_bank_tb.sv
module fetch_bkpt_bank_tb;
  localparam int N = 4;
  localparam int OW = $clog2(N + 1);
  localparam int SW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [OW-1:0] cfg_off = '0;
  logic [31:0] cfg_wdata = '0;
  logic fetch_valid = 0;
  logic [31:0] fetch_addr = '0;
  logic bp_hit, bp_upper;
  logic [SW-1:0] bp_slot;

  fetch_bkpt_bank #(.NUM_SLOTS(N)) u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit done = 0;

  bit m_glob;
  bit m_en[N], m_lo[N], m_hi[N];
  int unsigned m_addr[N];
  bit e_hit, e_up;
  int e_slot;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_glob = 0; e_hit = 0; e_slot = 0; e_up = 0;
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_addr[i] = 0; end
    end else begin
      e_hit = 0; e_slot = 0; e_up = fetch_addr[1];
      if (fetch_valid && m_glob)
        for (int i = 0; i < N; i++)
          if (!e_hit && m_en[i] && m_addr[i] == (fetch_addr % 32'h2000_0000) / 4
              && (fetch_addr[1] ? m_hi[i] : m_lo[i])) begin
            e_hit = 1; e_slot = i;
          end
      if (cfg_we) begin
        if (cfg_off == 0) begin
          if (cfg_wdata[1]) m_glob = cfg_wdata[0];
        end else if (int'(cfg_off) <= N) begin
          m_en[cfg_off-1]   = cfg_wdata[0];
          m_lo[cfg_off-1]   = cfg_wdata[30];
          m_hi[cfg_off-1]   = cfg_wdata[31];
          m_addr[cfg_off-1] = (cfg_wdata % 32'h2000_0000) / 4;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (bp_hit !== e_hit) begin
      failures++;
      $display("FAIL %s hit act=%0b exp=%0b", phase, bp_hit, e_hit);
    end else if (e_hit && (int'(bp_slot) != e_slot || bp_upper !== e_up)) begin
      failures++;
      $display("FAIL %s slot/upper act=%0d/%0b exp=%0d/%0b", phase, bp_slot, bp_upper, e_slot, e_up);
    end
  end

  function automatic logic [31:0] mk(input logic [31:0] a, input bit lo, hi, en);
    return (a & 32'h1FFF_FFFC) | {hi, lo, 29'b0, en};
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    cfg_we = 1; cfg_off = OW'(off); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fe(input logic [31:0] a);
    fetch_valid = 1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    checks++;
    if (bp_hit !== 1'b0) begin failures++; $display("FAIL R1 hit act=%0b exp=0", bp_hit); end
    fe(32'h0); fe(32'h100); @(negedge clk);

    phase = "R2";
    wr(1, mk(32'h100, 1, 0, 1));
    wr(0, 32'h1);
    fe(32'h100); @(negedge clk);
    wr(0, 32'h3);
    fe(32'h100); fe(32'h102); @(negedge clk);
    wr(0, 32'h0);
    fe(32'h100); @(negedge clk);
    wr(0, 32'h3);

    phase = "R3";
    wr(3, mk(32'h2000, 1, 0, 1) | 32'h2000_0002);
    fe(32'hE000_2000); fe(32'h0000_2001); fe(32'h0000_2004); @(negedge clk);

    phase = "R4";
    wr(2, mk(32'h300, 0, 1, 1));
    fe(32'h300); fe(32'h302);
    wr(2, mk(32'h300, 1, 1, 1));
    fe(32'h300); fe(32'h302);
    wr(2, mk(32'h300, 0, 0, 1));
    fe(32'h300); fe(32'h302); @(negedge clk);

    phase = "R5";
    wr(2, mk(32'h300, 1, 1, 0));
    fe(32'h300); fe(32'h302);
    wr(2, mk(32'h300, 1, 1, 1));
    wr(0, 32'h2);
    fe(32'h302);
    wr(0, 32'h3);
    fe(32'h302); @(negedge clk);

    phase = "R6";
    wr(4, mk(32'h500, 1, 1, 1));
    wr(3, mk(32'h500, 1, 1, 1));
    fe(32'h500); fe(32'h502);
    wr(2, mk(32'h500, 1, 0, 1));
    fe(32'h500); fe(32'h502); @(negedge clk);

    phase = "R7";
    fe(32'h100); fe(32'h502); fe(32'h500); fe(32'h100);
    fetch_valid = 1; fetch_addr = 32'h100;
    cfg_we = 1; cfg_off = OW'(1); cfg_wdata = mk(32'h100, 1, 0, 0);
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    fetch_valid = 0; @(negedge clk);

    phase = "R8";
    wr(1, mk(32'h100, 1, 0, 1));
    fetch_valid = 0; fetch_addr = 32'h100; @(negedge clk); @(negedge clk);

    phase = "R9";
    wr(5, mk(32'h700, 1, 1, 1));
    wr(6, mk(32'h700, 1, 1, 1));
    wr(7, 32'h0);
    fe(32'h700); fe(32'h100); fe(32'h702); @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule